// File: doc/BRIEF.md
# Nonvolatile Memory Command Controller

This block sits between a byte-wide register bus and a small byte array that stands in for nonvolatile storage. Software first loads an operation code into the command register, then an address and, where needed, data. The operation starts on one of three triggers. An execute bit starts action-class operations, and it is guarded by an unlock key. A read of the memory window starts read-class operations. A write to the memory window starts write-class operations.

Writes hold the controller busy for a set number of cycles before the array changes. A CRC-16 can be computed over the whole array or over an address range, one byte per cycle. While the controller is busy, its configuration registers are frozen. Lock bits block reads or writes separately for the application, table and boot sections and for the external-programmer path. A blocked access leaves the array alone and raises a sticky error flag.

Top module: `nvm_cmd_ctrl`

## Requirements
- R1: After reset all registers read 0, the `busy` output is low and every array byte is 0.
- R2: Register map offsets: 0 command, 1 control A, 2 control B, 3 address, 4 range limit, 5 data low, 6 data high, 7 status, 8 key, 9 lock, 10 memory window. With command 0x02, a window write stores its data in data low. It raises busy for WR_CYCLES (default 8) cycles, starting on the cycle after the trigger. On the edge where busy drops, it writes the byte to the array at the address register.
- R3: With command 0x01, a window read returns the array byte at the address register in the same cycle and also copies it into data low.
- R4: While busy, bus writes to command, control A, control B, address and range limit are ignored.
- R5: Writing 1 to control A bit 0 (execute) is honoured only when it falls in one of the 4 cycles that follow a write of 0xD8 to the key register. An execute write in any later cycle is dropped.
- R6: An accepted execute with command 0x03 computes a CRC over the whole array and is busy one cycle per byte. When busy drops, data high:data low hold the CRC-16 result (polynomial 0x1021, seed 0xFFFF, MSB first, no reflection).
- R7: Command 0x04 computes the same CRC from the address register up to the range limit, inclusive. If the limit is below the address, only the byte at the address is processed.
- R8: On the self-programming path (control B bit 0 = 0), the lock register bits block access by section. Bit 0 blocks application reads and bit 1 blocks application writes. Bits 2 and 3 do the same for the table section (the TABLE_SIZE bytes below boot). Bits 4 and 5 do the same for the boot section (the top BOOT_SIZE bytes). A blocked access leaves the array unchanged, does not raise busy, and reads as 0.
- R9: On the external path (control B bit 0 = 1), only lock bit 6 (read) and lock bit 7 (write) apply, whatever the section.
- R10: A blocked access sets status bit 1. The bit stays set until it is cleared by writing 1 to it. Status bit 7 mirrors busy.
- R11: Lock bits can only be set. A write to the lock register ORs into its current value.
- R12: A window access whose command does not match its class does nothing, and a window read in that case returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| busy | output | 1 | Operation in progress |

## Verification
Writes go to addresses in each of the three sections with different data bytes. Reading them back with the read command shows the window decode and the address path. A reading of 0 after a mismatched command shows that the trigger class is honoured. Execute writes are placed at three and at four idle cycles after the key write, which locates the edge of the unlock window exactly. The CRC is checked over the full array, over a multi-byte range and over a reversed range. Each CRC result is compared with a CRC the bench computes from its own model of the array, so both the byte walk and the range bounds are checked. The same lock and address pairs are tried on both paths, which shows whether the section locks or the external locks were applied.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
   localparam logic [3:0] OFF_CMD    = 4'd0;
   localparam logic [3:0] OFF_CTLA   = 4'd1;
   localparam logic [3:0] OFF_CTLB   = 4'd2;
   localparam logic [3:0] OFF_ADDR   = 4'd3;
   localparam logic [3:0] OFF_LIMIT  = 4'd4;
   localparam logic [3:0] OFF_DLO    = 4'd5;
   localparam logic [3:0] OFF_DHI    = 4'd6;
   localparam logic [3:0] OFF_STAT   = 4'd7;
   localparam logic [3:0] OFF_KEY    = 4'd8;
   localparam logic [3:0] OFF_LOCK   = 4'd9;
   localparam logic [3:0] OFF_WIN    = 4'd10;

   localparam logic [7:0] OP_READ     = 8'h01;
   localparam logic [7:0] OP_WRITE    = 8'h02;
   localparam logic [7:0] OP_CRC_ALL  = 8'h03;
   localparam logic [7:0] OP_CRC_SPAN = 8'h04;

   // lock bit positions; read bit is even, write bit is the next one up
   localparam int LK_APP  = 0;
   localparam int LK_TBL  = 2;
   localparam int LK_BOOT = 4;
   localparam int LK_EXT  = 6;

   typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_CRC} seq_state_t;
endpackage

// File: rtl/nvm_lock_check.sv
module nvm_lock_check #(
   parameter int AW         = 8,
   parameter int BOOT_SIZE  = 32,
   parameter int TABLE_SIZE = 32
) (
   input  logic [AW-1:0] addr,
   input  logic          is_wr,
   input  logic          ext_path,
   input  logic [7:0]    locks,
   output logic          allow
);
   import nvm_pkg::*;
   localparam int DEPTH      = 1 << AW;
   localparam int BOOT_BASE  = DEPTH - BOOT_SIZE;
   localparam int TABLE_BASE = BOOT_BASE - TABLE_SIZE;
   localparam logic [AW:0] BOOT_B = (AW+1)'(BOOT_BASE);
   localparam logic [AW:0] TBL_B  = (AW+1)'(TABLE_BASE);

   logic in_boot, in_tbl;
   assign in_boot = ({1'b0, addr} >= BOOT_B);

   generate
      if (TABLE_SIZE == 0) begin : g_no_tbl
         assign in_tbl = 1'b0;
      end else begin : g_tbl
         assign in_tbl = ({1'b0, addr} >= TBL_B) && !in_boot;
      end
   endgenerate

   int base;
   always_comb begin
      if (ext_path)     base = LK_EXT;
      else if (in_boot) base = LK_BOOT;
      else if (in_tbl)  base = LK_TBL;
      else              base = LK_APP;
      allow = !locks[base + (is_wr ? 1 : 0)];
   end
endmodule

// File: rtl/nvm_crc_step.sv
module nvm_crc_step #(
   parameter logic [15:0] POLY = 16'h1021
) (
   input  logic [15:0] crc_in,
   input  logic [7:0]  din,
   output logic [15:0] crc_out
);
   logic [15:0] c;
   always_comb begin
      c = crc_in ^ {din, 8'h00};
      for (int b = 0; b < 8; b++) begin
         c = c[15] ? ((c << 1) ^ POLY) : (c << 1);
      end
      crc_out = c;
   end
endmodule

// File: rtl/nvm_seq.sv
module nvm_seq #(
   parameter int AW        = 8,
   parameter int WR_CYCLES = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_wr,
   input  logic          start_crc,
   input  logic [AW-1:0] crc_lo,
   input  logic [AW-1:0] crc_hi,
   input  logic [7:0]    byte_in,
   output logic [AW-1:0] ptr,
   output logic          busy,
   output logic          commit_wr,
   output logic          crc_done,
   output logic [15:0]   crc_val
);
   import nvm_pkg::*;
   localparam int CW = $clog2(WR_CYCLES + 1);

   seq_state_t    state;
   logic [CW-1:0] cnt;
   logic [AW-1:0] last;
   logic [15:0]   crc_q, crc_nx;

   nvm_crc_step u_step (.crc_in(crc_q), .din(byte_in), .crc_out(crc_nx));

   assign busy      = (state != ST_IDLE);
   assign commit_wr = (state == ST_WRITE) && (cnt == '0);
   assign crc_done  = (state == ST_CRC) && (ptr == last);
   assign crc_val   = crc_nx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         ptr   <= '0;
         last  <= '0;
         crc_q <= 16'hFFFF;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start_wr) begin
                  state <= ST_WRITE;
                  cnt   <= CW'(WR_CYCLES - 1);
               end else if (start_crc) begin
                  state <= ST_CRC;
                  ptr   <= crc_lo;
                  last  <= crc_hi;
                  crc_q <= 16'hFFFF;
               end
            end
            ST_WRITE: begin
               if (cnt == '0) state <= ST_IDLE;
               else           cnt   <= cnt - 1'b1;
            end
            ST_CRC: begin
               crc_q <= crc_nx;
               ptr   <= ptr + 1'b1;
               if (ptr == last) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/nvm_cmd_ctrl.sv
module nvm_cmd_ctrl #(
   parameter int         AW         = 8,
   parameter int         BOOT_SIZE  = 32,
   parameter int         TABLE_SIZE = 32,
   parameter int         WR_CYCLES  = 8,
   parameter int         KEY_WIN    = 4,
   parameter logic [7:0] KEY_VAL    = 8'hD8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_we,
   input  logic       bus_re,
   input  logic [3:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       busy
);
   import nvm_pkg::*;
   localparam int DEPTH = 1 << AW;
   localparam int KW    = $clog2(KEY_WIN + 1);

   generate
      if (AW < 2 || AW > 8) begin : g_bad_aw
         $error("AW must be within 2..8");
      end
      if (BOOT_SIZE + TABLE_SIZE >= DEPTH) begin : g_bad_sect
         $error("boot and table sections must leave an application section");
      end
      if (WR_CYCLES < 1 || KEY_WIN < 1) begin : g_bad_cnt
         $error("WR_CYCLES and KEY_WIN must be at least 1");
      end
   endgenerate

   logic [7:0]    cmd_q, data_lo, data_hi, lock_q, hold_data;
   logic          path_q, err_q;
   logic [AW-1:0] addr_q, limit_q, ptr, crc_lo, crc_hi;
   logic [KW-1:0] key_cnt;
   logic [7:0]    mem [DEPTH];
   logic          commit_wr, crc_done, allow_rd, allow_wr;
   logic [15:0]   crc_val;

   logic w_cmd, w_ctla, w_ctlb, w_addr, w_lim, w_lo, w_hi, w_stat, w_key, w_lock;
   logic win_wr, win_rd, wr_trig, rd_trig, start_wr, wr_denied, rd_ok, rd_denied;
   logic exec_req, exec_ok, start_crc;

   always_comb begin
      w_cmd  = bus_we && bus_addr == OFF_CMD;
      w_ctla = bus_we && bus_addr == OFF_CTLA;
      w_ctlb = bus_we && bus_addr == OFF_CTLB;
      w_addr = bus_we && bus_addr == OFF_ADDR;
      w_lim  = bus_we && bus_addr == OFF_LIMIT;
      w_lo   = bus_we && bus_addr == OFF_DLO;
      w_hi   = bus_we && bus_addr == OFF_DHI;
      w_stat = bus_we && bus_addr == OFF_STAT;
      w_key  = bus_we && bus_addr == OFF_KEY;
      w_lock = bus_we && bus_addr == OFF_LOCK;
      win_wr = bus_we && bus_addr == OFF_WIN;
      win_rd = bus_re && bus_addr == OFF_WIN;
   end

   nvm_lock_check #(.AW(AW), .BOOT_SIZE(BOOT_SIZE), .TABLE_SIZE(TABLE_SIZE)) u_lk_rd (
      .addr(addr_q), .is_wr(1'b0), .ext_path(path_q), .locks(lock_q), .allow(allow_rd));
   nvm_lock_check #(.AW(AW), .BOOT_SIZE(BOOT_SIZE), .TABLE_SIZE(TABLE_SIZE)) u_lk_wr (
      .addr(addr_q), .is_wr(1'b1), .ext_path(path_q), .locks(lock_q), .allow(allow_wr));

   always_comb begin
      wr_trig   = win_wr && !busy && cmd_q == OP_WRITE;
      rd_trig   = win_rd && !busy && cmd_q == OP_READ;
      start_wr  = wr_trig && allow_wr;
      wr_denied = wr_trig && !allow_wr;
      rd_ok     = rd_trig && allow_rd;
      rd_denied = rd_trig && !allow_rd;
      exec_req  = w_ctla && bus_wdata[0] && !busy;
      exec_ok   = exec_req && key_cnt != '0;
      start_crc = exec_ok && (cmd_q == OP_CRC_ALL || cmd_q == OP_CRC_SPAN);
      if (cmd_q == OP_CRC_ALL) begin
         crc_lo = '0;
         crc_hi = '1;
      end else begin
         crc_lo = addr_q;
         crc_hi = (limit_q >= addr_q) ? limit_q : addr_q;
      end
   end

   nvm_seq #(.AW(AW), .WR_CYCLES(WR_CYCLES)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_crc(start_crc),
      .crc_lo(crc_lo), .crc_hi(crc_hi), .byte_in(mem[ptr]), .ptr(ptr),
      .busy(busy), .commit_wr(commit_wr), .crc_done(crc_done), .crc_val(crc_val));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q     <= '0;
         path_q    <= 1'b0;
         addr_q    <= '0;
         limit_q   <= '0;
         data_lo   <= '0;
         data_hi   <= '0;
         lock_q    <= '0;
         err_q     <= 1'b0;
         key_cnt   <= '0;
         hold_data <= '0;
      end else begin
         if (w_cmd  && !busy) cmd_q   <= bus_wdata;
         if (w_ctlb && !busy) path_q  <= bus_wdata[0];
         if (w_addr && !busy) addr_q  <= bus_wdata[AW-1:0];
         if (w_lim  && !busy) limit_q <= bus_wdata[AW-1:0];
         if (w_lock)          lock_q  <= lock_q | bus_wdata;

         if (crc_done) begin
            data_lo <= crc_val[7:0];
            data_hi <= crc_val[15:8];
         end else begin
            if (w_lo)     data_lo <= bus_wdata;
            if (w_hi)     data_hi <= bus_wdata;
            if (rd_ok)    data_lo <= mem[addr_q];
            if (start_wr) data_lo <= bus_wdata;
         end
         if (start_wr) hold_data <= bus_wdata;

         if (wr_denied || rd_denied)      err_q <= 1'b1;
         else if (w_stat && bus_wdata[1]) err_q <= 1'b0;

         if (w_key && bus_wdata == KEY_VAL) key_cnt <= KW'(KEY_WIN);
         else if (exec_ok)                  key_cnt <= '0;
         else if (key_cnt != '0)            key_cnt <= key_cnt - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (commit_wr) begin
         mem[addr_q] <= hold_data;
      end
   end

   always_comb begin
      unique case (bus_addr)
         OFF_CMD:   bus_rdata = cmd_q;
         OFF_CTLB:  bus_rdata = {7'd0, path_q};
         OFF_ADDR:  bus_rdata = 8'(addr_q);
         OFF_LIMIT: bus_rdata = 8'(limit_q);
         OFF_DLO:   bus_rdata = data_lo;
         OFF_DHI:   bus_rdata = data_hi;
         OFF_STAT:  bus_rdata = {busy, 5'd0, err_q, 1'b0};
         OFF_LOCK:  bus_rdata = lock_q;
         OFF_WIN:   bus_rdata = rd_ok ? mem[addr_q] : 8'd0;
         default:   bus_rdata = 8'd0;
      endcase
   end
endmodule

// File: rtl/nvm_cmd_ctrl_chk.sv
module nvm_cmd_ctrl_chk #(
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_we,
   input logic [3:0]    bus_addr,
   input logic [7:0]    bus_wdata,
   input logic          busy,
   input logic [7:0]    cmd_q,
   input logic [AW-1:0] addr_q,
   input logic          err_q,
   input logic          key_open,
   input logic          start_crc,
   input logic          start_wr,
   input logic          wr_denied,
   input logic          commit_wr
);
   import nvm_pkg::*;

   a_r4_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy && bus_we && bus_addr == OFF_CMD |=> cmd_q == $past(cmd_q));
   a_r4_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy && bus_we && bus_addr == OFF_ADDR |=> addr_q == $past(addr_q));
   a_r5_exec_keyed: assert property (@(posedge clk) disable iff (!rst_n)
      start_crc |-> key_open);
   a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start_wr |=> busy);
   a_r2_commit_ends: assert property (@(posedge clk) disable iff (!rst_n)
      commit_wr |=> !busy);
   a_r8_denied_flags: assert property (@(posedge clk) disable iff (!rst_n)
      wr_denied |=> err_q && !busy);
   a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_q && !(bus_we && bus_addr == OFF_STAT && bus_wdata[1]) |=> err_q);
endmodule

bind nvm_cmd_ctrl nvm_cmd_ctrl_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .busy(busy), .cmd_q(cmd_q), .addr_q(addr_q),
   .err_q(err_q), .key_open(key_cnt != '0), .start_crc(start_crc),
   .start_wr(start_wr), .wr_denied(wr_denied), .commit_wr(commit_wr));

// File: tb/tb_nvm_cmd_ctrl.sv
module tb_nvm_cmd_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_we = 1'b0, bus_re = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       busy;

   int total = 0, bad = 0, m_busy = 0;
   bit run = 0, finished = 0;
   logic [7:0] m_mem [256];
   logic [7:0] v;

   nvm_cmd_ctrl dut (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy));

   always #10 clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1 bus_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk); bus_re = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk); #1 bus_re = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   function automatic logic [15:0] crc_over(input int lo, input int hi);
      logic [15:0] c = 16'hFFFF;
      for (int a = lo; a <= hi; a++) begin
         c = c ^ {m_mem[a], 8'h00};
         for (int b = 0; b < 8; b++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
      end
      return c;
   endfunction

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // reference busy trace, compared every cycle (R2, R6, R7)
   always @(negedge clk) begin
      if (rst_n && run) begin
         chk("R2,R6 busy trace", busy, (m_busy > 0) ? 1 : 0);
         if (m_busy > 0) m_busy--;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [15:0] exp_crc;
      for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
      idle(3);
      rst_n = 1'b1;
      run = 1;
      idle(1);

      // R1 reset state
      rd(4'd7, v); chk("R1 status", v, 0);
      rd(4'd0, v); chk("R1 command", v, 0);
      rd(4'd5, v); chk("R1 data low", v, 0);
      rd(4'd9, v); chk("R1 lock", v, 0);
      chk("R1 busy", busy, 0);

      // R2 writes into each section, R4 frozen registers during the first
      wr(4'd0, 8'h02);
      begin
         int addrs[3] = '{8'h05, 8'hC3, 8'hE7};
         int datas[3] = '{8'hA5, 8'h3C, 8'h5A};
         for (int k = 0; k < 3; k++) begin
            wr(4'd3, 8'(addrs[k]));
            wr(4'd10, 8'(datas[k]));
            m_busy = 8; m_mem[addrs[k]] = 8'(datas[k]);
            rd(4'd5, v); chk("R2 data low holds window data", v, datas[k]);
            if (k == 0) begin
               wr(4'd0, 8'h01); wr(4'd3, 8'h77); wr(4'd2, 8'h01); wr(4'd4, 8'h09);
               idle(4);
               rd(4'd0, v); chk("R4 command frozen", v, 8'h02);
               rd(4'd3, v); chk("R4 address frozen", v, 8'h05);
               rd(4'd2, v); chk("R4 control B frozen", v, 0);
               rd(4'd4, v); chk("R4 limit frozen", v, 0);
            end else idle(9);
         end
         // R3 read back
         wr(4'd0, 8'h01);
         for (int k = 0; k < 3; k++) begin
            wr(4'd3, 8'(addrs[k]));
            rd(4'd10, v); chk("R3 window read", v, datas[k]);
            rd(4'd5, v);  chk("R3 data low copy", v, datas[k]);
         end
      end

      // R12 mismatched class
      wr(4'd0, 8'h00); wr(4'd3, 8'h05); wr(4'd10, 8'h11);
      idle(10);
      wr(4'd0, 8'h02);
      rd(4'd10, v); chk("R12 read under write command", v, 0);
      wr(4'd0, 8'h01);
      rd(4'd10, v); chk("R12 array untouched", v, 8'hA5);

      // R5 key window
      wr(4'd0, 8'h03);
      wr(4'd1, 8'h01); idle(2);
      chk("R5 execute without key", busy, 0);
      wr(4'd8, 8'hD8); idle(4); wr(4'd1, 8'h01); idle(2);
      chk("R5 execute after window", busy, 0);
      wr(4'd8, 8'hD8); idle(3); wr(4'd1, 8'h01);
      m_busy = 256;
      // R6 full-array CRC
      idle(258);
      exp_crc = crc_over(0, 255);
      rd(4'd5, v); chk("R6 crc low", v, exp_crc[7:0]);
      rd(4'd6, v); chk("R6 crc high", v, exp_crc[15:8]);

      // R7 range CRC
      wr(4'd0, 8'h04); wr(4'd3, 8'hC0); wr(4'd4, 8'hE8);
      wr(4'd8, 8'hD8); wr(4'd1, 8'h01);
      m_busy = 8'hE8 - 8'hC0 + 1;
      idle(45);
      exp_crc = crc_over(8'hC0, 8'hE8);
      rd(4'd5, v); chk("R7 range crc low", v, exp_crc[7:0]);
      rd(4'd6, v); chk("R7 range crc high", v, exp_crc[15:8]);
      wr(4'd4, 8'h02);
      wr(4'd8, 8'hD8); wr(4'd1, 8'h01);
      m_busy = 1;
      idle(3);
      exp_crc = crc_over(8'hC0, 8'hC0);
      rd(4'd5, v); chk("R7 reversed range low", v, exp_crc[7:0]);
      rd(4'd6, v); chk("R7 reversed range high", v, exp_crc[15:8]);

      // R8 section locks, R10 sticky error
      wr(4'd9, 8'h02);
      wr(4'd0, 8'h02); wr(4'd3, 8'h05); wr(4'd10, 8'h99);
      idle(10);
      rd(4'd7, v); chk("R10 error set", v, 8'h02);
      wr(4'd0, 8'h01);
      rd(4'd10, v); chk("R8 locked write left array", v, 8'hA5);
      wr(4'd7, 8'h00);
      rd(4'd7, v); chk("R10 write 0 keeps error", v, 8'h02);
      wr(4'd7, 8'h02);
      rd(4'd7, v); chk("R10 write 1 clears error", v, 0);
      wr(4'd0, 8'h02); wr(4'd3, 8'hC3); wr(4'd10, 8'h3D);
      m_busy = 8; m_mem[8'hC3] = 8'h3D;
      idle(10);
      wr(4'd0, 8'h01);
      rd(4'd10, v); chk("R8 table write unaffected", v, 8'h3D);
      wr(4'd9, 8'h10);
      wr(4'd3, 8'hE7);
      rd(4'd10, v); chk("R8 boot read blocked", v, 0);
      rd(4'd7, v);  chk("R10 error from read", v, 8'h02);
      wr(4'd7, 8'h02);

      // R11 tighten-only
      wr(4'd9, 8'h00);
      rd(4'd9, v); chk("R11 lock kept", v, 8'h12);

      // R9 external path
      wr(4'd9, 8'h80);
      wr(4'd2, 8'h01);
      rd(4'd10, v); chk("R9 ext read ignores boot lock", v, 8'h5A);
      wr(4'd0, 8'h02); wr(4'd3, 8'hC5); wr(4'd10, 8'h66);
      idle(10);
      rd(4'd7, v); chk("R9 ext write lock", v, 8'h02);
      wr(4'd7, 8'h02);
      wr(4'd2, 8'h00);
      wr(4'd10, 8'h66);
      m_busy = 8; m_mem[8'hC5] = 8'h66;
      idle(10);
      wr(4'd0, 8'h01);
      rd(4'd10, v); chk("R9 self path table write", v, 8'h66);
      rd(4'd7, v);  chk("R9 no error on self path", v, 0);

      idle(2);
      finish_run();
   end
endmodule